// File: doc/BRIEF.md
# Sector-Partitioned Cache Victim Allocator

This block chooses which way of a set-associative cache gets replaced on a miss when the cache's capacity is shared between four sectors. Each request carries its sector in address bits above the translated range. Those bits are set by software, so the same line can be placed in a different sector by changing only those bits. A small register file holds a way budget for each sector. The allocator tracks which sector owns each way of every set, keeps an age order of the ways in each set, and picks a victim so that each sector drifts toward its budget. It never flushes anything.

The block is built for one of two cache levels, chosen by a parameter. In the first-level variant the sector is the two-bit field at address bits 57:56. In the second-level variant only bit 56 comes from the address. A separate selector register chooses which of two budget pairs is in force, and that choice forms the upper sector bit. Tag lookup, data storage, coherence and translation are left to the surrounding cache. The allocator receives a hit/miss flag and, on a hit, the hit way.

Top module: `sector_way_alloc`

## Requirements
- R1: In the first-level variant (LEVEL = LVL_FIRST) the sector of a request is req_addr_i[57:56], and it selects budget register 0 to 3 by that value.
- R2: In the second-level variant the sector is {sel, req_addr_i[56]}. Here sel is bit 0 of configuration register 4, and budget registers 0 and 1 form pair 0 while 2 and 3 form pair 1.
- R3: The set index is req_addr_i[LINE_W +: log2(SETS)] only. Address bits 52 and above (sector bits included) never change the set that is read or updated.
- R4: victim_valid_o pulses for exactly one cycle, in the cycle after a request with req_hit_i = 0. victim_way_o carries the chosen way in that cycle. Idle cycles and hits give no pulse.
- R5: A miss fills the chosen way. The way becomes valid, is owned by the requesting sector and becomes most recently used. After reset, empty ways are taken from way WAYS-1 down to way 0.
- R6: If the requester owns fewer valid ways in the set than its budget, the victim is the least recently used way among invalid ways and ways of other sectors that exceed their own budgets. If no such way exists, the victim is the least recently used way not owned by the requester.
- R7: If the requester owns at least its budget, the victim is its own least recently used way.
- R8: A budget of 0 acts as 1, and a budget above WAYS acts as WAYS.
- R9: A hit only makes the hit way most recently used. It changes no ownership or valid state and produces no victim pulse.
- R10: A budget write takes effect from the next request on. Lines already held stay in place and simply become eligible once their sector is over budget.
- R11: After reset victim_valid_o is 0, all ways are invalid and every budget equals RST_QUOTA.
- R12: In the first-level variant, writes to configuration addresses 4 to 7 have no effect on any later victim choice. In the second-level variant, addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup result present this cycle |
| req_addr_i | input | ADDR_W | Request address, including the sector bits |
| req_hit_i | input | 1 | 1 = hit, 0 = miss (fill requested) |
| req_hit_way_i | input | log2(WAYS) | Way that hit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | 0-3 budget registers, 4 pair selector |
| cfg_data_i | input | clog2(WAYS+1) | Write data |
| victim_valid_o | output | 1 | Victim result strobe |
| victim_way_o | output | log2(WAYS) | Chosen victim way |

## Verification
The bench goes after budget changes that leave a sector above its new budget. A design that ignored over-budget foreign ways would keep evicting invalid or in-budget lines and starve the other sectors. It drives budgets of zero and above WAYS; without the clamp a sector with budget zero would never be under budget and would find no own way to replace. It varies the address bits above the translated range while keeping the set fixed. If the set index were taken from the wrong bits, the fill would land in another set and later victims would disagree with the reference model. Hits on ways of other sectors, and selector writes sent to the first-level variant, are mixed into random traffic. An ownership change on a hit, or a decode of register 4 in the wrong variant, would show up as a wrong victim later on.

// File: rtl/sw_alloc_pkg.sv
package sw_alloc_pkg;
   typedef enum logic {
      LVL_FIRST  = 1'b0,
      LVL_SECOND = 1'b1
   } level_e;

   localparam int SECT_N      = 4;
   localparam int SECT_W      = 2;
   localparam int SECT_LSB    = 56;
   localparam int XLATE_BITS  = 52;
   localparam int CFG_AW      = 3;
   localparam int CFG_SEL_IDX = 4;

   typedef logic [SECT_W-1:0] sect_t;
endpackage

// File: rtl/sw_cfg_regs.sv
module sw_cfg_regs
   import sw_alloc_pkg::*;
#(
   parameter int     WAYS      = 8,
   parameter int     QW        = 4,
   parameter int     RST_QUOTA = 8,
   parameter level_e LEVEL     = LVL_FIRST
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         cfg_we_i,
   input  logic [CFG_AW-1:0]            cfg_addr_i,
   input  logic [QW-1:0]                cfg_data_i,
   input  sect_t                        sect_bits_i,
   output sect_t                        req_sect_o,
   output logic [SECT_N-1:0][QW-1:0]    quota_eff_o
);
   logic [SECT_N-1:0][QW-1:0] quota_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SECT_N; s++) quota_q[s] <= QW'(RST_QUOTA);
      end else if (cfg_we_i && cfg_addr_i < CFG_AW'(SECT_N)) begin
         quota_q[cfg_addr_i[SECT_W-1:0]] <= cfg_data_i;
      end
   end

   for (genvar g = 0; g < SECT_N; g++) begin : g_clamp
      always_comb begin
         if (quota_q[g] == '0)             quota_eff_o[g] = QW'(1);
         else if (quota_q[g] > QW'(WAYS))  quota_eff_o[g] = QW'(WAYS);
         else                              quota_eff_o[g] = quota_q[g];
      end

      AST_QUOTA_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         quota_eff_o[g] >= QW'(1) && quota_eff_o[g] <= QW'(WAYS)); // R8
   end

   if (LEVEL == LVL_FIRST) begin : g_first
      logic unused_cfg_hi;
      assign unused_cfg_hi = ^cfg_data_i;
      assign req_sect_o    = sect_bits_i;
   end else begin : g_second
      logic sel_q;
      logic unused_sect_hi;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            sel_q <= 1'b0;
         else if (cfg_we_i && cfg_addr_i == CFG_AW'(CFG_SEL_IDX))
            sel_q <= cfg_data_i[0];
      end
      assign unused_sect_hi = sect_bits_i[1];
      assign req_sect_o     = {sel_q, sect_bits_i[0]};
   end
endmodule

// File: rtl/sw_set_state.sv
module sw_set_state
   import sw_alloc_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int SETS  = 16,
   localparam int WW   = $clog2(WAYS),
   localparam int SW   = $clog2(SETS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [SW-1:0]                  rd_set_i,
   output logic [WAYS-1:0]                rd_valid_o,
   output logic [WAYS-1:0][SECT_W-1:0]    rd_owner_o,
   output logic [WAYS-1:0][WW-1:0]        rd_rank_o,
   input  logic                           upd_en_i,
   input  logic                           upd_fill_i,
   input  logic [WW-1:0]                  upd_way_i,
   input  sect_t                          upd_sect_i
);
   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:0][SECT_W-1:0] owner_q;
   logic [SETS-1:0][WAYS-1:0][WW-1:0]     rank_q;

   assign rd_valid_o = valid_q[rd_set_i];
   assign rd_owner_o = owner_q[rd_set_i];
   assign rd_rank_o  = rank_q[rd_set_i];

   // Age ranks: 0 = most recent, WAYS-1 = least recent.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WW'(w);
         end
      end else if (upd_en_i) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WW'(w) == upd_way_i)
               rank_q[rd_set_i][w] <= '0;
            else if (rank_q[rd_set_i][w] < rank_q[rd_set_i][upd_way_i])
               rank_q[rd_set_i][w] <= rank_q[rd_set_i][w] + WW'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= '0;
         owner_q <= '0;
      end else if (upd_en_i && upd_fill_i) begin
         valid_q[rd_set_i][upd_way_i] <= 1'b1;
         owner_q[rd_set_i][upd_way_i] <= upd_sect_i;
      end
   end

   AST_HIT_KEEPS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_en_i && !upd_fill_i |=> $stable(owner_q) && $stable(valid_q)); // R9

   AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_en_i && upd_fill_i |=> $countones(valid_q) >= $countones($past(valid_q))); // R5
endmodule

// File: rtl/sw_victim_pick.sv
module sw_victim_pick
   import sw_alloc_pkg::*;
#(
   parameter int  WAYS = 8,
   parameter int  QW   = 4,
   localparam int WW   = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]                rd_valid_i,
   input  logic [WAYS-1:0][SECT_W-1:0]    rd_owner_i,
   input  logic [WAYS-1:0][WW-1:0]        rd_rank_i,
   input  sect_t                          req_sect_i,
   input  logic [SECT_N-1:0][QW-1:0]      quota_eff_i,
   output logic                           under_o,
   output logic [WW-1:0]                  pick_way_o
);
   logic [SECT_N-1:0][QW-1:0] cnt;
   logic [SECT_N-1:0]         over;
   logic [WAYS-1:0]           own_m, prime_m, foreign_m, elig_m;
   logic [WW-1:0]             best_rank;
   logic                      found;

   always_comb begin
      for (int s = 0; s < SECT_N; s++) begin
         cnt[s] = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (rd_valid_i[w] && rd_owner_i[w] == SECT_W'(s)) cnt[s] = cnt[s] + QW'(1);
         end
      end
   end

   for (genvar g = 0; g < SECT_N; g++) begin : g_over
      assign over[g] = cnt[g] > quota_eff_i[g];
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_mask
      assign own_m[w]     = rd_valid_i[w] && rd_owner_i[w] == req_sect_i;
      assign foreign_m[w] = !own_m[w];
      assign prime_m[w]   = !rd_valid_i[w] ||
                            (rd_owner_i[w] != req_sect_i && over[rd_owner_i[w]]);
   end

   assign under_o = cnt[req_sect_i] < quota_eff_i[req_sect_i];

   always_comb begin
      if (!under_o)            elig_m = own_m;
      else if (prime_m != '0)  elig_m = prime_m;
      else                     elig_m = foreign_m;
   end

   always_comb begin
      pick_way_o = '0;
      best_rank  = '0;
      found      = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (elig_m[w] && (!found || rd_rank_i[w] > best_rank)) begin
            found      = 1'b1;
            pick_way_o = WW'(w);
            best_rank  = rd_rank_i[w];
         end
      end
   end
endmodule

// File: rtl/sector_way_alloc.sv
module sector_way_alloc
   import sw_alloc_pkg::*;
#(
   parameter int     WAYS      = 8,
   parameter int     SETS      = 16,
   parameter int     ADDR_W    = 64,
   parameter int     LINE_W    = 6,
   parameter int     RST_QUOTA = WAYS,
   parameter level_e LEVEL     = LVL_FIRST,
   localparam int    WW        = $clog2(WAYS),
   localparam int    SW        = $clog2(SETS),
   localparam int    QW        = $clog2(WAYS + 1)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_valid_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic                req_hit_i,
   input  logic [WW-1:0]       req_hit_way_i,
   input  logic                cfg_we_i,
   input  logic [CFG_AW-1:0]   cfg_addr_i,
   input  logic [QW-1:0]       cfg_data_i,
   output logic                victim_valid_o,
   output logic [WW-1:0]       victim_way_o
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_W + SW > XLATE_BITS) begin : g_bad_index
      $error("set index must stay below the translated address range");
   end
   if (ADDR_W < SECT_LSB + SECT_W) begin : g_bad_addr
      $error("ADDR_W too small to carry the sector bits");
   end
   if (RST_QUOTA < 0 || RST_QUOTA >= (1 << QW)) begin : g_bad_rstq
      $error("RST_QUOTA does not fit the budget register");
   end

   logic [SW-1:0]             set_idx;
   sect_t                     sect_bits, req_sect;
   logic [SECT_N-1:0][QW-1:0] quota_eff;
   logic [WAYS-1:0]           rd_valid;
   logic [WAYS-1:0][SECT_W-1:0] rd_owner;
   logic [WAYS-1:0][WW-1:0]   rd_rank;
   logic                      under;
   logic [WW-1:0]             pick_way;
   logic                      miss;
   logic                      unused_addr;

   assign set_idx     = req_addr_i[LINE_W +: SW];
   assign sect_bits   = req_addr_i[SECT_LSB +: SECT_W];
   assign miss        = req_valid_i && !req_hit_i;
   assign unused_addr = ^req_addr_i;

   sw_cfg_regs #(
      .WAYS(WAYS), .QW(QW), .RST_QUOTA(RST_QUOTA), .LEVEL(LEVEL)
   ) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we_i),
      .cfg_addr_i  (cfg_addr_i),
      .cfg_data_i  (cfg_data_i),
      .sect_bits_i (sect_bits),
      .req_sect_o  (req_sect),
      .quota_eff_o (quota_eff)
   );

   sw_set_state #(
      .WAYS(WAYS), .SETS(SETS)
   ) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_set_i   (set_idx),
      .rd_valid_o (rd_valid),
      .rd_owner_o (rd_owner),
      .rd_rank_o  (rd_rank),
      .upd_en_i   (req_valid_i),
      .upd_fill_i (!req_hit_i),
      .upd_way_i  (req_hit_i ? req_hit_way_i : pick_way),
      .upd_sect_i (req_sect)
   );

   sw_victim_pick #(
      .WAYS(WAYS), .QW(QW)
   ) u_pick (
      .rd_valid_i  (rd_valid),
      .rd_owner_i  (rd_owner),
      .rd_rank_i   (rd_rank),
      .req_sect_i  (req_sect),
      .quota_eff_i (quota_eff),
      .under_o     (under),
      .pick_way_o  (pick_way)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         victim_valid_o <= 1'b0;
         victim_way_o   <= '0;
      end else begin
         victim_valid_o <= miss;
         if (miss) victim_way_o <= pick_way;
      end
   end

   AST_VICTIM_AFTER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      victim_valid_o |-> $past(req_valid_i && !req_hit_i)); // R4

   AST_HIT_NO_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && req_hit_i |=> !victim_valid_o); // R9

   AST_OVER_TAKES_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss && !under |-> rd_valid[pick_way] && rd_owner[pick_way] == req_sect); // R7

   AST_UNDER_SPARES_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss && under |-> !(rd_valid[pick_way] && rd_owner[pick_way] == req_sect)); // R6

   AST_WAY_REPORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss |=> victim_way_o == $past(pick_way)); // R4
endmodule

// File: tb/sector_way_alloc_bench.sv
module sector_way_alloc_bench;
   import sw_alloc_pkg::*;

   localparam int WAYS = 8;
   localparam int SETS = 16;
   localparam int WW   = 3;
   localparam int QW   = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          req_valid, req_hit, cfg_we;
   logic [63:0]   req_addr;
   logic [WW-1:0] hit_way;
   logic [2:0]    cfg_addr;
   logic [QW-1:0] cfg_data;
   logic          vv0, vv1;
   logic [WW-1:0] vw0, vw1;

   int n_tests = 0;
   int n_fail  = 0;
   int stamp;
   bit mv[2][SETS][WAYS];
   int mo[2][SETS][WAYS];
   int ma[2][SETS][WAYS];
   int mq[2][4];
   int msel[2];

   sector_way_alloc #(.WAYS(WAYS), .SETS(SETS), .LEVEL(LVL_FIRST)) u_sector_way_alloc (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
      .req_hit_i(req_hit), .req_hit_way_i(hit_way), .cfg_we_i(cfg_we),
      .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
      .victim_valid_o(vv0), .victim_way_o(vw0));

   sector_way_alloc #(.WAYS(WAYS), .SETS(SETS), .LEVEL(LVL_SECOND)) u_sector_way_alloc_l2 (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
      .req_hit_i(req_hit), .req_hit_way_i(hit_way), .cfg_we_i(cfg_we),
      .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
      .victim_valid_o(vv1), .victim_way_o(vw1));

   task automatic chk(bit ok, string rq, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // R1 / R2: sector decode for each variant
   function automatic int msect(int d, logic [63:0] a);
      if (d == 0) return int'(a[57:56]);
      return msel[1] * 2 + int'(a[56]);
   endfunction

   // R8: clamped budget
   function automatic int qeff(int d, int s);
      if (mq[d][s] == 0) return 1;
      if (mq[d][s] > WAYS) return WAYS;
      return mq[d][s];
   endfunction

   function automatic int mpick(int d, int st, int sec);
      int cnt[4];
      int best;
      bit under;
      for (int s = 0; s < 4; s++) cnt[s] = 0;
      for (int w = 0; w < WAYS; w++) if (mv[d][st][w]) cnt[mo[d][st][w]]++;
      under = cnt[sec] < qeff(d, sec);
      best = -1;
      for (int pass = 0; pass < 2; pass++) begin
         if (best < 0) begin
            for (int w = 0; w < WAYS; w++) begin
               bit own, el;
               own = mv[d][st][w] && mo[d][st][w] == sec;
               if (!under)        el = own;
               else if (pass == 0) el = !mv[d][st][w] ||
                                        (!own && cnt[mo[d][st][w]] > qeff(d, mo[d][st][w]));
               else               el = !own;
               if (el && (best < 0 || ma[d][st][w] < ma[d][st][best])) best = w;
            end
         end
      end
      return best;
   endfunction

   task automatic do_miss(logic [63:0] a, string rq, int expl);
      int st, e0, e1;
      st = int'(a[9:6]);
      e0 = mpick(0, st, msect(0, a));
      e1 = mpick(1, st, msect(1, a));
      req_valid = 1'b1; req_hit = 1'b0; req_addr = a;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      chk(vv0 == 1'b1, "R4 victim strobe (first level)", int'(vv0), 1);
      chk(vv1 == 1'b1, "R4 victim strobe (second level)", int'(vv1), 1);
      chk(int'(vw0) == e0, {rq, " first level"}, int'(vw0), e0);
      chk(int'(vw1) == e1, {rq, " second level"}, int'(vw1), e1);
      if (expl >= 0) chk(int'(vw0) == expl, {rq, " directed"}, int'(vw0), expl);
      mv[0][st][e0] = 1'b1; mo[0][st][e0] = msect(0, a); ma[0][st][e0] = ++stamp;
      mv[1][st][e1] = 1'b1; mo[1][st][e1] = msect(1, a); ma[1][st][e1] = ++stamp;
      @(negedge clk);
      chk(vv0 == 1'b0 && vv1 == 1'b0, "R4 strobe lasts one cycle", int'(vv0), 0);
   endtask

   task automatic do_hit(logic [63:0] a, int w);
      int st;
      st = int'(a[9:6]);
      req_valid = 1'b1; req_hit = 1'b1; req_addr = a; hit_way = WW'(w);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_hit = 1'b0;
      chk(vv0 == 1'b0 && vv1 == 1'b0, "R9 hit gives no victim", int'(vv0 | vv1), 0);
      ma[0][st][w] = ++stamp;
      ma[1][st][w] = ++stamp;
   endtask

   // R10 / R12: writes update the model from the next request on
   task automatic do_cfg(int ad, int dat);
      cfg_we = 1'b1; cfg_addr = 3'(ad); cfg_data = QW'(dat);
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
      if (ad < 4) begin
         mq[0][ad] = dat;
         mq[1][ad] = dat;
      end else if (ad == 4) begin
         msel[1] = dat & 1;
      end
   endtask

   function automatic logic [63:0] mk_addr(int st, int sec);
      logic [63:0] a;
      a = {$urandom, $urandom};
      a[9:6]   = 4'(st);
      a[57:56] = 2'(sec);
      return a;
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] a;
      void'($urandom(32'd20210517));
      stamp = WAYS;
      for (int d = 0; d < 2; d++) begin
         msel[d] = 0;
         for (int s = 0; s < 4; s++) mq[d][s] = WAYS;
         for (int st = 0; st < SETS; st++)
            for (int w = 0; w < WAYS; w++) begin
               mv[d][st][w] = 1'b0; mo[d][st][w] = 0; ma[d][st][w] = WAYS - 1 - w;
            end
      end
      rst_n = 1'b0; req_valid = 1'b0; req_hit = 1'b0; req_addr = '0; hit_way = '0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(vv0 == 1'b0 && vv1 == 1'b0, "R11 no strobe in reset", int'(vv0 | vv1), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vv0 == 1'b0 && vv1 == 1'b0, "R11 idle after reset", int'(vv0 | vv1), 0);

      // R5: empty set fills from the top way down
      do_miss(mk_addr(0, 0), "R5 first fill", WAYS - 1);
      do_miss(mk_addr(0, 0), "R5 second fill", WAYS - 2);

      // R3: upper bits varied, set held
      a = mk_addr(3, 0); a[55:52] = 4'hF; a[63:58] = 6'h2A;
      do_miss(a, "R3 upper bits ignored", WAYS - 1);
      a = mk_addr(3, 0); a[55:52] = 4'h0; a[63:58] = 6'h15;
      do_miss(a, "R3 same set reached", WAYS - 2);

      // R8: zero budget acts as one
      do_cfg(1, 0);
      do_miss(mk_addr(1, 1), "R8 zero budget first", WAYS - 1);
      do_miss(mk_addr(1, 1), "R8 zero budget reuses own", WAYS - 1);
      do_cfg(1, WAYS + 3);
      do_miss(mk_addr(1, 1), "R8 large budget clamps", WAYS - 2);

      // R10 / R6 / R7: shrink a budget after the set is full
      for (int i = 0; i < WAYS; i++) do_miss(mk_addr(2, 0), "R5 fill set", WAYS - 1 - i);
      do_hit(mk_addr(2, 3), WAYS - 1);
      do_cfg(0, 2);
      do_miss(mk_addr(2, 2), "R6 R10 over-budget foreign way", WAYS - 2);
      do_miss(mk_addr(2, 0), "R7 own way at budget", WAYS - 3);

      // R12 / R2: selector register
      do_cfg(4, 1);
      do_miss(mk_addr(5, 0), "R12 R2 selector write", WAYS - 1);
      do_miss(mk_addr(5, 1), "R1 R2 sector decode", WAYS - 2);
      do_cfg(6, 3);
      do_miss(mk_addr(5, 2), "R12 unused address", -1);

      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 8)
            do_cfg($urandom_range(0, 7), $urandom_range(0, WAYS + 2));
         else if (r < 35)
            do_hit(mk_addr($urandom_range(8, 11), $urandom_range(0, 3)), $urandom_range(0, WAYS - 1));
         else
            do_miss(mk_addr($urandom_range(8, 11), $urandom_range(0, 3)), "R6 R7 random victim", -1);
      end

      summary();
      $finish;
   end
endmodule